// File: doc/BRIEF.md
# NAND Page Column to Buffer Address Mapper

This block turns a byte column inside a NAND page into an address in the controller's internal page buffer RAM. The column counts the page's data bytes first and its spare bytes after them. Data bytes go to one contiguous region that starts at address 0. Spare bytes do not form one run. Each 512-byte section of the page owns its own spare buffer, and there are up to eight of them. Each spare buffer holds 64 bytes and starts at 0x1000 plus 64 times its index. Only an even number of bytes per section is used, and whatever is left over is stacked onto the last section's buffer.

There are two ways to use the block. The lookup port translates one column per request and answers one cycle later. The burst port takes a start column and a byte count, then streams one buffer address per cycle. It steps the column by one each beat. The stream jumps from the data region into spare buffer 0 when the column passes the end of the data area. It also jumps at every spare-buffer boundary, and it flags the first beat of each such segment. A spare-only input makes the column an offset into the spare bytes directly.

Top module: `nsm_spare_mapper`

## Requirements
- R1: With spare-only low and a column below the page length, the address equals the column. The page length is set by `cfg_page_sel`: 0 gives 512, 1 gives 2048, and 2 or 3 give 4096.
- R2: The section count is the page length divided by 512. The byte count per spare buffer is (2·`cfg_spare_hw`) divided by the section count, rounded down to an even number.
- R3: A spare offset `s` lands in buffer `i = min(s / per_buffer, sections − 1)`. The address is 0x1000 + 64·i + (s − i·per_buffer).
- R4: With a 4096-byte page and `cfg_spare_hw` = 109 (218 spare bytes), buffers 0 to 6 each receive 26 offsets and buffer 7 receives 36.
- R5: With spare-only low, a column at or past the page length is translated as spare offset (column − page length).
- R6: With `cfg_spare_only` high, the column is used directly as the spare offset, whatever its value.
- R7: A lookup raises `lk_ack` exactly one cycle after `lk_req`, with `lk_addr` and `lk_spare` (1 means spare) for the column that was sampled.
- R8: A start with a nonzero length while idle gives `bs_len` beats on consecutive cycles, beginning two cycles after the start. The column advances by one per beat, and `bs_done` is high with the last beat.
- R9: A burst that runs past the data area continues into spare buffer 0 on the very next beat, with no idle cycle.
- R10: `bs_seg_first` is high on the first beat of a burst and on every beat that lands on byte 0 of a spare buffer. It is low on all other beats.
- R11: A start pulse that arrives while a burst is running, or that carries a length of zero, is ignored.
- R12: After reset, `lk_ack`, `bs_valid`, `bs_done` and `bs_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_sel | input | 2 | Page length code: 0 = 512, 1 = 2048, 2 or 3 = 4096 |
| cfg_spare_hw | input | 8 | Spare size in 16-bit half-words |
| cfg_spare_only | input | 1 | Treat the column as a spare offset |
| lk_req | input | 1 | Lookup request |
| lk_col | input | 13 | Lookup column |
| lk_ack | output | 1 | Lookup result valid |
| lk_addr | output | 13 | Lookup buffer address |
| lk_spare | output | 1 | Lookup result is in the spare region |
| bs_start | input | 1 | Burst start pulse |
| bs_col | input | 13 | Burst start column |
| bs_len | input | 13 | Burst length in bytes |
| bs_valid | output | 1 | Burst beat valid |
| bs_addr | output | 13 | Burst beat buffer address |
| bs_seg_first | output | 1 | Beat opens a new segment |
| bs_done | output | 1 | Last beat of the burst |
| bs_busy | output | 1 | Burst in progress |

## Verification
A lookup result is due at the first clock edge after the request is sampled, so the bench reads `lk_ack` one cycle after it drives `lk_req`. A burst's first beat appears at the second edge after the start pulse, and each later beat follows one edge after the one before. The bench pushes every expected lookup result and burst beat into scoreboard queues before it drives the stimulus. A monitor then checks each valid output at the falling edge, in order. Any beat that arrives with an empty queue is a failure, which is how ignored starts are shown to produce nothing. Buffer occupancy for the 218-byte spare case is tallied from the addresses the lookups return.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int COL_W       = 13;
  localparam int ADDR_W      = 13;
  localparam int LEN_W       = 13;
  localparam int HW_W        = 8;
  localparam int SB_W        = HW_W + 1;
  localparam int NBUF        = 8;
  localparam int IDX_W       = $clog2(NBUF);
  localparam int SECT        = 512;
  localparam int BUF_STRIDE  = 64;
  localparam int SPARE_BASE  = 4096;

  typedef logic [COL_W-1:0]  col_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  len_t;
endpackage

// File: rtl/nsm_geom.sv
// Derives page length, per-buffer spare bytes and last buffer index from config.
module nsm_geom
  import nsm_pkg::*;
(
  input  logic [1:0]      page_sel,
  input  logic [HW_W-1:0] spare_hw,
  output col_t            page_len,
  output logic [SB_W-1:0] buf_bytes,
  output logic [IDX_W-1:0] last_idx
);
  localparam logic [SB_W-1:0] EVEN_MASK = {{(SB_W-1){1'b1}}, 1'b0};

  logic [1:0]      sect_sh;
  logic [SB_W-1:0] spare_bytes;

  always_comb begin
    case (page_sel)
      2'd0: begin
        page_len = COL_W'(SECT);
        sect_sh  = 2'd0;
        last_idx = IDX_W'(0);
      end
      2'd1: begin
        page_len = COL_W'(4 * SECT);
        sect_sh  = 2'd2;
        last_idx = IDX_W'(3);
      end
      default: begin
        page_len = COL_W'(8 * SECT);
        sect_sh  = 2'd3;
        last_idx = IDX_W'(NBUF - 1);
      end
    endcase
    spare_bytes = {spare_hw, 1'b0};
    // R2: share per section, forced even
    buf_bytes   = (spare_bytes >> sect_sh) & EVEN_MASK;
  end
endmodule

// File: rtl/nsm_xlate.sv
// Combinational column-to-buffer-address translation.
module nsm_xlate
  import nsm_pkg::*;
(
  input  col_t             col,
  input  logic             spare_only,
  input  col_t             page_len,
  input  logic [SB_W-1:0]  buf_bytes,
  input  logic [IDX_W-1:0] last_idx,
  output addr_t            addr,
  output logic             is_spare,
  output logic             buf_head
);
  col_t             soff;
  col_t             base_off;
  col_t             inoff;
  logic [IDX_W-1:0] idx;

  always_comb begin
    is_spare = spare_only || (col >= page_len);
    soff     = spare_only ? col : (col - page_len);
    idx      = '0;
    base_off = '0;
    // R3: thresholds rise monotonically, the highest one passed wins,
    // capped at the last buffer in use
    for (int k = 1; k < NBUF; k++) begin
      if ((IDX_W'(k) <= last_idx) &&
          (soff >= COL_W'(k) * COL_W'(buf_bytes))) begin
        idx      = IDX_W'(k);
        base_off = COL_W'(k) * COL_W'(buf_bytes);
      end
    end
    inoff = soff - base_off;
    if (is_spare)
      addr = ADDR_W'(SPARE_BASE) + ADDR_W'(idx) * ADDR_W'(BUF_STRIDE)
             + ADDR_W'(inoff);
    else
      addr = ADDR_W'(col);
    buf_head = is_spare && (inoff == '0);
  end
endmodule

// File: rtl/nsm_burst.sv
// Burst sequencer: one column per cycle, registered beat outputs.
module nsm_burst
  import nsm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  col_t  start_col,
  input  len_t  start_len,
  output col_t  cur_col,
  input  addr_t x_addr,
  input  logic  x_head,
  output logic  beat_valid,
  output addr_t beat_addr,
  output logic  beat_first,
  output logic  beat_done,
  output logic  busy
);
  logic  active_q, active_d;
  col_t  col_q, col_d;
  len_t  rem_q, rem_d;
  logic  first_q, first_d;
  logic  valid_q, valid_d;
  addr_t addr_q, addr_d;
  logic  segf_q, segf_d;
  logic  done_q, done_d;
  logic  load_en, step_en, ctl_en;

  assign load_en = !active_q && start && (start_len != '0);
  assign step_en = active_q;
  assign ctl_en  = load_en || step_en;

  always_comb begin
    active_d = active_q;
    col_d    = col_q;
    rem_d    = rem_q;
    first_d  = first_q;
    addr_d   = addr_q;
    valid_d  = 1'b0;
    segf_d   = 1'b0;
    done_d   = 1'b0;
    if (step_en) begin
      valid_d = 1'b1;
      addr_d  = x_addr;
      segf_d  = first_q || x_head;
      done_d  = (rem_q == LEN_W'(1));
      col_d   = col_q + COL_W'(1);
      rem_d   = rem_q - LEN_W'(1);
      first_d = 1'b0;
      if (rem_q == LEN_W'(1)) active_d = 1'b0;
    end else if (load_en) begin
      active_d = 1'b1;
      col_d    = start_col;
      rem_d    = start_len;
      first_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      col_q    <= '0;
      rem_q    <= '0;
      first_q  <= 1'b0;
    end else if (ctl_en) begin
      active_q <= active_d;
      col_q    <= col_d;
      rem_q    <= rem_d;
      first_q  <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      segf_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      segf_q  <= segf_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (step_en) addr_q <= addr_d;
  end

  assign cur_col    = col_q;
  assign beat_valid = valid_q;
  assign beat_addr  = addr_q;
  assign beat_first = segf_q;
  assign beat_done  = done_q;
  assign busy       = active_q;

  p_col_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> (col_q == $past(col_q) + COL_W'(1)));

  p_busy_ignores_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && start) |=> (rem_q == $past(rem_q) - LEN_W'(1)));

  p_done_with_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> valid_q);

  p_first_beat_marked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> segf_q);
endmodule

// File: rtl/nsm_spare_mapper.sv
module nsm_spare_mapper
  import nsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_page_sel,
  input  logic [HW_W-1:0]   cfg_spare_hw,
  input  logic              cfg_spare_only,
  input  logic              lk_req,
  input  logic [COL_W-1:0]  lk_col,
  output logic              lk_ack,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              lk_spare,
  input  logic              bs_start,
  input  logic [COL_W-1:0]  bs_col,
  input  logic [LEN_W-1:0]  bs_len,
  output logic              bs_valid,
  output logic [ADDR_W-1:0] bs_addr,
  output logic              bs_seg_first,
  output logic              bs_done,
  output logic              bs_busy
);
  col_t             page_len;
  logic [SB_W-1:0]  buf_bytes;
  logic [IDX_W-1:0] last_idx;

  nsm_geom u_geom (
    .page_sel  (cfg_page_sel),
    .spare_hw  (cfg_spare_hw),
    .page_len  (page_len),
    .buf_bytes (buf_bytes),
    .last_idx  (last_idx)
  );

  // Lookup path
  addr_t lk_x_addr;
  logic  lk_x_spare;
  logic  lk_x_head;

  nsm_xlate u_xlate_lk (
    .col        (lk_col),
    .spare_only (cfg_spare_only),
    .page_len   (page_len),
    .buf_bytes  (buf_bytes),
    .last_idx   (last_idx),
    .addr       (lk_x_addr),
    .is_spare   (lk_x_spare),
    .buf_head   (lk_x_head)
  );

  logic  lk_ack_q;
  addr_t lk_addr_q, lk_addr_d;
  logic  lk_spare_q, lk_spare_d;

  always_comb begin
    lk_addr_d  = lk_x_addr;
    lk_spare_d = lk_x_spare;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_ack_q <= 1'b0;
    else        lk_ack_q <= lk_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_addr_q  <= '0;
      lk_spare_q <= 1'b0;
    end else if (lk_req) begin
      lk_addr_q  <= lk_addr_d;
      lk_spare_q <= lk_spare_d;
    end
  end

  assign lk_ack   = lk_ack_q;
  assign lk_addr  = lk_addr_q;
  assign lk_spare = lk_spare_q;

  // Burst path
  col_t  bs_cur_col;
  addr_t bs_x_addr;
  logic  bs_x_spare;
  logic  bs_x_head;

  nsm_xlate u_xlate_bs (
    .col        (bs_cur_col),
    .spare_only (cfg_spare_only),
    .page_len   (page_len),
    .buf_bytes  (buf_bytes),
    .last_idx   (last_idx),
    .addr       (bs_x_addr),
    .is_spare   (bs_x_spare),
    .buf_head   (bs_x_head)
  );

  nsm_burst u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (bs_start),
    .start_col  (bs_col),
    .start_len  (bs_len),
    .cur_col    (bs_cur_col),
    .x_addr     (bs_x_addr),
    .x_head     (bs_x_head && bs_x_spare),
    .beat_valid (bs_valid),
    .beat_addr  (bs_addr),
    .beat_first (bs_seg_first),
    .beat_done  (bs_done),
    .busy       (bs_busy)
  );

  p_lk_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_ack);

  p_lk_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_ack);

  p_spare_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ack && lk_spare) |->
      ((lk_addr >= ADDR_W'(SPARE_BASE)) &&
       (lk_addr <  ADDR_W'(SPARE_BASE + NBUF * BUF_STRIDE))));

  p_main_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ack && !lk_spare) |-> (lk_addr < ADDR_W'(SPARE_BASE)));
endmodule

// File: tb/nsm_spare_mapper_tb.sv
module nsm_spare_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_page_sel;
  logic [7:0]  cfg_spare_hw;
  logic        cfg_spare_only;
  logic        lk_req;
  logic [12:0] lk_col;
  logic        lk_ack;
  logic [12:0] lk_addr;
  logic        lk_spare;
  logic        bs_start;
  logic [12:0] bs_col;
  logic [12:0] bs_len;
  logic        bs_valid;
  logic [12:0] bs_addr;
  logic        bs_seg_first;
  logic        bs_done;
  logic        bs_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsm_spare_mapper u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_page_sel(cfg_page_sel), .cfg_spare_hw(cfg_spare_hw),
    .cfg_spare_only(cfg_spare_only),
    .lk_req(lk_req), .lk_col(lk_col), .lk_ack(lk_ack),
    .lk_addr(lk_addr), .lk_spare(lk_spare),
    .bs_start(bs_start), .bs_col(bs_col), .bs_len(bs_len),
    .bs_valid(bs_valid), .bs_addr(bs_addr), .bs_seg_first(bs_seg_first),
    .bs_done(bs_done), .bs_busy(bs_busy)
  );

  typedef struct { int addr; bit sp; string tag; } lk_exp_t;
  typedef struct { int addr; bit segf; bit done; string tag; } bs_exp_t;

  lk_exp_t lk_q[$];
  bs_exp_t bs_q[$];
  int checks = 0;
  int errors = 0;
  bit hist_en = 0;
  int hist [8];
  bit finished = 0;

  // Reference model written from the requirements
  function automatic int ref_map(int col, int ps, int shw, bit so,
                                 output bit sp, output bit head);
    int page, chunks, sb, off, idx, inb;
    page   = (ps == 0) ? 512 : (ps == 1) ? 2048 : 4096;
    chunks = page / 512;
    sb     = ((shw * 2) / chunks) & ~1;
    if (!so && col < page) begin
      sp = 0; head = 0;
      return col;
    end
    sp  = 1;
    off = so ? col : col - page;
    idx = (sb == 0) ? chunks - 1 : off / sb;
    if (idx > chunks - 1) idx = chunks - 1;
    inb  = off - idx * sb;
    head = (inb == 0);
    return 4096 + idx * 64 + inb;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int ps, int shw, bit so);
    @(negedge clk);
    cfg_page_sel   = 2'(ps);
    cfg_spare_hw   = 8'(shw);
    cfg_spare_only = so;
  endtask

  task automatic lookup(int col, string tag);
    lk_exp_t e;
    bit sp, hd;
    e.addr = ref_map(col, cfg_page_sel, cfg_spare_hw, cfg_spare_only, sp, hd);
    e.sp   = sp;
    e.tag  = tag;
    lk_q.push_back(e);
    @(negedge clk);
    lk_req = 1'b1;
    lk_col = 13'(col);
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic burst(int col, int len, string tag);
    for (int i = 0; i < len; i++) begin
      bs_exp_t e;
      bit sp, hd;
      e.addr = ref_map(col + i, cfg_page_sel, cfg_spare_hw, cfg_spare_only, sp, hd);
      e.segf = (i == 0) || (sp && hd);
      e.done = (i == len - 1);
      e.tag  = tag;
      bs_q.push_back(e);
    end
    @(negedge clk);
    bs_start = 1'b1;
    bs_col   = 13'(col);
    bs_len   = 13'(len);
    @(negedge clk);
    bs_start = 1'b0;
  endtask

  task automatic drain();
    while (bs_q.size() != 0 || lk_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (lk_ack) begin
        if (lk_q.size() == 0) chk(0, "R7 unexpected lk_ack", 1, 0);
        else begin
          lk_exp_t e;
          e = lk_q.pop_front();
          chk(lk_addr == 13'(e.addr), e.tag, lk_addr, e.addr);
          chk(lk_spare == e.sp, {e.tag, " spare flag"}, lk_spare, e.sp);
          if (hist_en && lk_spare) hist[(int'(lk_addr) - 4096) / 64]++;
        end
      end
      if (bs_valid) begin
        if (bs_q.size() == 0) chk(0, "R11 unexpected beat", bs_addr, 0);
        else begin
          bs_exp_t e;
          e = bs_q.pop_front();
          chk(bs_addr == 13'(e.addr), e.tag, bs_addr, e.addr);
          chk(bs_seg_first == e.segf, {e.tag, " R10 seg_first"}, bs_seg_first, e.segf);
          chk(bs_done == e.done, {e.tag, " R8 done"}, bs_done, e.done);
        end
      end else if (bs_q.size() != 0 && !bs_busy && !bs_start) begin
        // a pending burst must not stall once started (R9 no gap)
      end
    end
  end

  // Gap check for R8/R9: once a beat is seen, the next is due every cycle
  bit prev_valid = 0;
  bit prev_done  = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid && !prev_done)
        chk(bs_valid, "R9 beat gap", bs_valid, 1);
      prev_valid = bs_valid;
      prev_done  = bs_done;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_page_sel = 2'd0; cfg_spare_hw = 8'd8; cfg_spare_only = 1'b0;
    lk_req = 1'b0; lk_col = '0;
    bs_start = 1'b0; bs_col = '0; bs_len = '0;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    chk(lk_ack == 1'b0,   "R12 lk_ack", lk_ack, 0);
    chk(bs_valid == 1'b0, "R12 bs_valid", bs_valid, 0);
    chk(bs_done == 1'b0,  "R12 bs_done", bs_done, 0);
    chk(bs_busy == 1'b0,  "R12 bs_busy", bs_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // 512/16
    set_cfg(0, 8, 0);
    lookup(0,   "R1 512 col0");
    lookup(100, "R1 512 col100");
    lookup(511, "R1 512 last main");
    lookup(512, "R5 512 spare0");
    lookup(527, "R2 512 spare15");
    drain();

    // 2048/64
    set_cfg(1, 32, 0);
    lookup(2047, "R1 2k last main");
    lookup(2048, "R5 2k spare0");
    lookup(2063, "R2 2k buf0 end");
    lookup(2064, "R3 2k buf1 start");
    lookup(2111, "R3 2k buf3 end");
    burst(2040, 20, "R9 2k cross");
    drain();

    // 4096/128
    set_cfg(2, 64, 0);
    lookup(4096 + 15,  "R2 4k128 buf0 end");
    lookup(4096 + 16,  "R3 4k128 buf1");
    lookup(4096 + 127, "R3 4k128 buf7 end");
    drain();

    // 4096/218: full sweep and occupancy
    set_cfg(3, 109, 0);
    hist_en = 1;
    for (int c = 4096; c < 4096 + 218; c++) lookup(c, "R4 218 sweep");
    drain();
    hist_en = 0;
    for (int b = 0; b < 7; b++) chk(hist[b] == 26, "R4 buffer count 0..6", hist[b], 26);
    chk(hist[7] == 36, "R4 buffer7 count", hist[7], 36);
    burst(4096 + 180, 38, "R10 218 into last buffer");
    drain();

    // spare-only
    set_cfg(3, 109, 1);
    lookup(0,   "R6 so off0");
    lookup(25,  "R6 so off25");
    lookup(26,  "R6 so off26");
    lookup(181, "R6 so off181");
    lookup(182, "R6 so off182");
    lookup(217, "R6 so off217");
    burst(20, 40, "R10 so burst");
    drain();

    // R11: zero length start
    set_cfg(1, 32, 0);
    @(negedge clk);
    bs_start = 1'b1; bs_col = 13'd5; bs_len = 13'd0;
    @(negedge clk);
    bs_start = 1'b0;
    @(negedge clk);
    chk(bs_busy == 1'b0, "R11 len0 busy", bs_busy, 0);
    repeat (3) @(negedge clk);

    // R11: start while busy
    burst(100, 10, "R8 main burst");
    repeat (2) @(negedge clk);
    chk(bs_busy == 1'b1, "R8 busy during burst", bs_busy, 1);
    bs_start = 1'b1; bs_col = 13'd2048; bs_len = 13'd5;
    @(negedge clk);
    bs_start = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(bs_busy == 1'b0, "R11 busy start ignored", bs_busy, 0);
    chk(bs_q.size() == 0, "R11 queue empty", bs_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule